// File: doc/BRIEF.md
# Host Interrupt Cause Aggregator with Coalescing Hold

This block collects hardware event pulses into sticky cause bits and drives one level interrupt line toward the host. There are two status words. The main cause word gathers events from the rest of the chip. The secondary DMA status word gathers per-channel transfer events. Each DMA event also sets a summary bit in the main cause word in the same cycle. The host reads both words over a simple single-cycle register bus. It acknowledges a cause by writing 1 to that bit.

The interrupt line is the OR of the enabled causes. A programmable hold can delay it. Time is counted in ticks from a timebase input that pulses once every 32 µs. When the hold is non-zero, the line stays low until that many ticks have passed since masked causes first became pending. A pending high-priority receive status bypasses the hold. A second byte of the same control word sets a periodic timer, and each time that timer expires it raises the receive-periodic cause.

Registers are at byte offsets 0x0 (main cause, write 1 to clear), 0x4 (enable mask), 0x8 (DMA status, write 1 to clear) and 0xC (bits 7:0 hold length in ticks, bits 15:8 periodic length in ticks, bits 31:16 read as zero). Accesses to any other offset are ignored and read as zero.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the main cause, mask and DMA status words read 0, the control word reads 0x0000_0040, and `irq` is low.
- R2: A pulse on `hw_evt[i]` sets main cause bit i at the next clock edge, for the implemented bits 31, 29, 28, 27, 26, 25, 7, 6, 3, 1 and 0 (mask 0xBE0000CB). The bit stays set until it is cleared. Pulses on other bit positions leave them at 0.
- R3: Writing 1 to a bit of the main cause word or the DMA status word clears that bit. Writing 0 leaves the bit unchanged.
- R4: If an event on a bit and a write-1 clear of the same bit happen in the same cycle, the bit stays set.
- R5: DMA events on bits 31, 30, 17, 16, 1 and 0 (mask 0xC0030003) set the matching DMA status bits. Other DMA bit positions are not stored. In the same cycle, DMA bits 17, 16 or 30 set main bit 31, DMA bits 1 or 0 set main bit 27, and DMA bit 31 sets main bit 29.
- R6: When the hold length is 0, `irq` equals the OR of (main cause AND mask), with no added delay.
- R7: When the hold length N is non-zero, `irq` stays low while masked causes are pending. It goes high after the N-th tick counted from the cycle they first became pending.
- R8: While DMA status bit 30 (high-priority receive) is set and a masked cause is pending, `irq` is high regardless of the hold.
- R9: When the periodic length P is non-zero, every P-th tick sets main bit 28. When P is 0, the periodic timer never sets the bit.
- R10: The mask word stores only the implemented cause bits. The control word stores bits 15:0 and reads 0 in bits 31:16.
- R11: Once no masked cause is pending, the hold restarts. A later cause waits a full N ticks again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse every 32 µs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| hw_evt | input | 32 | Main cause event pulses |
| dma_evt | input | 32 | DMA channel event pulses |
| irq | output | 1 | Level interrupt to the host |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that event inputs are pulses rather than held levels. A held event would keep a bit set and hide every clear. They also assume that the bus does at most one access per cycle. The stimulus drives every event, tick and bus strobe high for exactly one clock and drops it before the next edge. It never raises read and write together, so each read returns the state left by the previous edge. Collisions between an event and a clear are produced on purpose, in a single cycle, only for the R4 check.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W = 32;

  // Main cause bit positions
  localparam int C_RX_DMA   = 31;
  localparam int C_HW_ERR   = 29;
  localparam int C_RX_PER   = 28;
  localparam int C_TX_DMA   = 27;
  localparam int C_QPTR     = 26;
  localparam int C_FW_ERR   = 25;
  localparam int C_RFKILL   = 7;
  localparam int C_HOT      = 6;
  localparam int C_SW_RX    = 3;
  localparam int C_WAKE     = 1;
  localparam int C_ALIVE    = 0;

  // DMA status bit positions
  localparam int D_ERR      = 31;
  localparam int D_HIPRI    = 30;
  localparam int D_RX1      = 17;
  localparam int D_RX0      = 16;
  localparam int D_TX1      = 1;
  localparam int D_TX0      = 0;

  localparam logic [DATA_W-1:0] CAUSE_IMPL = 32'hBE00_00CB;
  localparam logic [DATA_W-1:0] DMA_IMPL   = 32'hC003_0003;

  // Register word indices (byte address / 4)
  localparam int IDX_CAUSE = 0;
  localparam int IDX_MASK  = 1;
  localparam int IDX_DMA   = 2;
  localparam int IDX_CTRL  = 3;

  // Next value of one write-1-to-clear bit; a new event wins over a clear.
  function automatic logic w1c_bit(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction

  // Main cause bits that a set of DMA events raises.
  function automatic logic [DATA_W-1:0] dma_summary(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] s;
    s = '0;
    s[C_RX_DMA] = d[D_RX1] | d[D_RX0] | d[D_HIPRI];
    s[C_TX_DMA] = d[D_TX1] | d[D_TX0];
    s[C_HW_ERR] = d[D_ERR];
    return s;
  endfunction
endpackage

// File: rtl/cause_bank.sv
module cause_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_en,
  input  logic [W-1:0] clr_data,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= irq_agg_pkg::w1c_bit(q[i], clr_en & clr_data[i], set[i]);
      end
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end

  p_w1c_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q & $past(clr_data & ~set & IMPL)) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set & IMPL)) |=> ((q & $past(set & IMPL)) == $past(set & IMPL)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] hold_len,
  input  logic          pend,
  input  logic          bypass,
  output logic          irq,
  output logic          fired
);
  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_inc;
  logic          reach;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign reach   = cnt_inc >= {1'b0, hold_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!pend) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!fired && tick) begin
      if (reach) fired <= 1'b1;
      else       cnt   <= cnt_inc[CW-1:0];
    end
  end

  assign irq = pend & ((hold_len == '0) | fired | bypass);

  p_fire_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fired) |-> $past(tick));

  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !fired);
endmodule

// File: rtl/period_timer.sv
module period_timer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic          pulse
);
  logic [PW-1:0] cnt;
  logic [PW:0]   cnt_inc;
  logic          enabled;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign enabled = period != '0;
  assign pulse   = tick & enabled & (cnt_inc >= {1'b0, period});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!enabled) cnt <= '0;
    else if (tick)     cnt <= pulse ? '0 : cnt_inc[PW-1:0];
  end

  p_pulse_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (tick && period != '0));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int HOLD_W  = 8,
  parameter int PER_W   = 8,
  parameter logic [HOLD_W-1:0] HOLD_RST = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       hw_evt,
  input  logic [31:0]       dma_evt,
  output logic              irq
);
  localparam int CTRL_W = HOLD_W + PER_W;
  localparam int IDX_W  = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              wr_cause, wr_mask, wr_dma, wr_ctrl;
  logic [31:0]       cause_q, dma_q, mask_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [31:0]       cause_set, dma_set;
  logic              per_pulse;
  logic              pend, bypass, hold_fired;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = bus_addr[1:0] == 2'b00;
  assign wr_cause = bus_wr & aligned & (idx == IDX_W'(IDX_CAUSE));
  assign wr_mask  = bus_wr & aligned & (idx == IDX_W'(IDX_MASK));
  assign wr_dma   = bus_wr & aligned & (idx == IDX_W'(IDX_DMA));
  assign wr_ctrl  = bus_wr & aligned & (idx == IDX_W'(IDX_CTRL));

  assign dma_set = dma_evt & DMA_IMPL;
  always_comb begin
    cause_set = hw_evt | dma_summary(dma_set);
    cause_set[C_RX_PER] = cause_set[C_RX_PER] | per_pulse;
    cause_set = cause_set & CAUSE_IMPL;
  end

  cause_bank #(.W(32), .IMPL(CAUSE_IMPL)) u_cause (
    .clk(clk), .rst_n(rst_n), .clr_en(wr_cause), .clr_data(bus_wdata),
    .set(cause_set), .q(cause_q));

  cause_bank #(.W(32), .IMPL(DMA_IMPL)) u_dma (
    .clk(clk), .rst_n(rst_n), .clr_en(wr_dma), .clr_data(bus_wdata),
    .set(dma_set), .q(dma_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= {{PER_W{1'b0}}, HOLD_RST};
    end else begin
      if (wr_mask) mask_q <= bus_wdata & CAUSE_IMPL;
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
    end
  end

  period_timer #(.PW(PER_W)) u_per (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .period(ctrl_q[CTRL_W-1:HOLD_W]), .pulse(per_pulse));

  assign pend   = |(cause_q & mask_q);
  assign bypass = dma_q[D_HIPRI];

  hold_timer #(.CW(HOLD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold_len(ctrl_q[HOLD_W-1:0]),
    .pend(pend), .bypass(bypass), .irq(irq), .fired(hold_fired));

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && aligned) begin
      case (idx)
        IDX_W'(IDX_CAUSE): bus_rdata = cause_q;
        IDX_W'(IDX_MASK):  bus_rdata = mask_q;
        IDX_W'(IDX_DMA):   bus_rdata = dma_q;
        IDX_W'(IDX_CTRL):  bus_rdata = 32'(ctrl_q);
        default:           bus_rdata = '0;
      endcase
    end
  end

  p_irq_needs_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((cause_q & mask_q) != '0));

  p_hipri_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_q[D_HIPRI] && (cause_q & mask_q) != '0) |-> irq);

  p_summary_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_evt[D_RX0] || dma_evt[D_RX1]) |=> cause_q[C_RX_DMA]);

  p_held_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[HOLD_W-1:0] != '0 && !hold_fired && !dma_q[D_HIPRI]) |-> !irq);
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CAUSE = 8'h00, A_MASK = 8'h04, A_DMA = 8'h08, A_CTRL = 8'h0C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] hw_evt = '0, dma_evt = '0;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_evt(hw_evt), .dma_evt(dma_evt), .irq(irq));

  // Monitor: compares read data against the scoreboard away from the edge
  always @(negedge clk) begin
    if (bus_rd) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (bus_rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s: read 0x%08h expected 0x%08h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic drive(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [31:0] hw, input logic [31:0] dm, input logic tk);
    @(posedge clk); #1;
    bus_wr = wr; bus_addr = a; bus_wdata = d; hw_evt = hw; dma_evt = dm; tick = tk;
    @(posedge clk); #1;
    bus_wr = 1'b0; hw_evt = '0; dma_evt = '0; tick = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, a, d, '0, '0, 1'b0);
  endtask

  task automatic hw(input logic [31:0] e);
    drive(1'b0, 8'h00, '0, e, '0, 1'b0);
  endtask

  task automatic dm(input logic [31:0] e);
    drive(1'b0, 8'h00, '0, '0, e, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00, '0, '0, '0, 1'b1);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s: irq %0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    rd(A_CAUSE, 32'h0, "R1 cause");
    rd(A_MASK,  32'h0, "R1 mask");
    rd(A_DMA,   32'h0, "R1 dma");
    rd(A_CTRL,  32'h40, "R1 ctrl");

    // R2 sticky set, unimplemented bits stay 0
    wr(A_CTRL, 32'h0);
    hw(32'hFFFF_FFFF);
    rd(A_CAUSE, 32'hBE00_00CB, "R2 all events");
    rd(A_DMA, 32'h0, "R2 dma untouched");
    chk_irq(1'b0, "R6 masked off");

    // R10 mask storage, R6 direct irq
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, 32'hBE00_00CB, "R10 mask impl bits");
    chk_irq(1'b1, "R6 irq with mask");
    wr(A_MASK, 32'h1);
    chk_irq(1'b1, "R6 bit0 enabled");

    // R3 write-1-clear
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, 32'hBE00_00CB, "R3 write zero no effect");
    wr(A_CAUSE, 32'h1);
    rd(A_CAUSE, 32'hBE00_00CA, "R3 clear bit0");
    chk_irq(1'b0, "R6 irq drops after clear");
    wr(A_CAUSE, 32'hFFFF_FFFF);
    rd(A_CAUSE, 32'h0, "R3 clear all");

    // R4 event wins over clear
    hw(32'h8);
    drive(1'b1, A_CAUSE, 32'h9, 32'h1, '0, 1'b0);
    rd(A_CAUSE, 32'h1, "R4 set wins, other bit cleared");
    wr(A_CAUSE, 32'hFFFF_FFFF);

    // R5 DMA summaries
    dm(32'h0001_0000);
    rd(A_CAUSE, 32'h8000_0000, "R5 rx summary");
    rd(A_DMA,   32'h0001_0000, "R5 rx dma bit");
    wr(A_CAUSE, 32'hFFFF_FFFF); wr(A_DMA, 32'hFFFF_FFFF);
    dm(32'h0000_0002);
    rd(A_CAUSE, 32'h0800_0000, "R5 tx summary");
    wr(A_CAUSE, 32'hFFFF_FFFF); wr(A_DMA, 32'hFFFF_FFFF);
    dm(32'h8000_0000);
    rd(A_CAUSE, 32'h2000_0000, "R5 error summary");
    wr(A_CAUSE, 32'hFFFF_FFFF); wr(A_DMA, 32'hFFFF_FFFF);
    dm(32'hFFFF_FFFF);
    rd(A_DMA,   32'hC003_0003, "R5 dma impl bits");
    rd(A_CAUSE, 32'hA800_0000, "R5 all summaries");
    wr(A_DMA, 32'h0003_0000);
    rd(A_DMA, 32'hC000_0003, "R3 dma partial clear");
    wr(A_CAUSE, 32'hFFFF_FFFF); wr(A_DMA, 32'hFFFF_FFFF);

    // R7 hold, R11 restart
    wr(A_CTRL, 32'h3);
    wr(A_MASK, 32'h1);
    hw(32'h1);
    chk_irq(1'b0, "R7 held at start");
    ticks(2);
    chk_irq(1'b0, "R7 held after 2 ticks");
    ticks(1);
    chk_irq(1'b1, "R7 released after 3 ticks");
    wr(A_CAUSE, 32'h1);
    chk_irq(1'b0, "R11 low after clear");
    hw(32'h1);
    chk_irq(1'b0, "R11 held again");
    ticks(2);
    chk_irq(1'b0, "R11 still held");
    ticks(1);
    chk_irq(1'b1, "R11 released");
    wr(A_CAUSE, 32'hFFFF_FFFF);

    // R8 high-priority bypass
    wr(A_MASK, 32'h8000_0000);
    dm(32'h4000_0000);
    chk_irq(1'b1, "R8 bypass immediate");
    wr(A_DMA, 32'h4000_0000);
    chk_irq(1'b0, "R8 hold resumes");
    wr(A_CAUSE, 32'hFFFF_FFFF);

    // R9 periodic
    wr(A_MASK, 32'h0);
    wr(A_CTRL, 32'h0400);
    ticks(3);
    rd(A_CAUSE, 32'h0, "R9 before period");
    ticks(1);
    rd(A_CAUSE, 32'h1000_0000, "R9 period reached");
    wr(A_CAUSE, 32'hFFFF_FFFF);
    ticks(4);
    rd(A_CAUSE, 32'h1000_0000, "R9 second period");
    wr(A_CTRL, 32'h0);
    wr(A_CAUSE, 32'hFFFF_FFFF);
    ticks(5);
    rd(A_CAUSE, 32'h0, "R9 disabled");

    // R10 control storage
    wr(A_CTRL, 32'hFFFF_1234);
    rd(A_CTRL, 32'h0000_1234, "R10 ctrl width");
    wr(A_CTRL, 32'h0);

    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: %0d reads outstanding, expected 0", sb.size());
    end
    finish_run();
  end
endmodule